// File: doc/BRIEF.md
# Tagged Register File

This block is a multi-ported register file. Each entry holds a data word and a 4-bit type tag. A tag of zero means the entry is free. Any legal nonzero tag means the entry is busy and holds a typed value that later operations may reuse. Only codes 0 through 13 are legal.

Port A is the first source of an operation and port B is the second. Both read ports are combinational and return the data and tag of the addressed entry. When the write port stores a result, the destination takes the tag held by the first source entry. Two per-operand bits choose, for each source, whether its tag is cleared at the end of the cycle or kept.

A separate tag-load port lets auxiliary operations set a tag directly. A busy vector gives the issue stage one flag per entry. Decoding and execution are outside the block; those units only drive its ports.

Top module: `tagged_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every tag and data word becomes zero and `tl_err_o` becomes low. After release, `busy_o` is all zeros and every read returns tag 0 and data 0.
- R2: `ra_data`/`ra_tag` and `rb_data`/`rb_tag` show the current contents of the entry at `ra_addr` and `rb_addr` in the same cycle, with no clock edge in between.
- R3: When `wr_en` is high at an edge, the entry `wr_addr` stores `wr_data`. Its tag becomes the tag that entry `ra_addr` held before that edge, and that value may be 0.
- R4: When `clr_a` (or `clr_b`) is high at an edge, the tag of entry `ra_addr` (or `rb_addr`) becomes 0 after the edge. The data word of that entry is kept.
- R5: The tag of an entry not touched by a write, a clear or an accepted tag load keeps its value. In particular, a source with its clear bit low keeps its tag.
- R6: When the write destination is also a source being cleared in the same cycle, the write wins. The entry ends with the inherited tag.
- R7: A tag load (`tl_en` high) with code 0..13 sets the tag of `tl_addr`. Codes 14 and 15 are rejected and leave the tag unchanged. A rejected load drives `tl_err_o` high for exactly the one cycle after the edge; otherwise `tl_err_o` is low.
- R8: When a write and an accepted tag load target the same entry in the same cycle, the write wins and the entry takes the inherited tag.
- R9: `busy_o[i]` is 1 exactly when the tag of entry i is nonzero. It changes only after the clock edge that changes the tag.
- R10: When an accepted tag load and a clear target the same entry in the same cycle, the tag load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_addr | input | 5 | First source / read port A address |
| ra_data | output | 32 | Data of entry `ra_addr` |
| ra_tag | output | 4 | Tag of entry `ra_addr` |
| rb_addr | input | 5 | Second source / read port B address |
| rb_data | output | 32 | Data of entry `rb_addr` |
| rb_tag | output | 4 | Tag of entry `rb_addr` |
| clr_a | input | 1 | Clear the tag of the first source at this edge |
| clr_b | input | 1 | Clear the tag of the second source at this edge |
| wr_en | input | 1 | Write result; destination inherits the first source tag |
| wr_addr | input | 5 | Destination entry |
| wr_data | input | 32 | Result data |
| tl_en | input | 1 | Direct tag load request |
| tl_addr | input | 5 | Tag load target entry |
| tl_tag | input | 4 | Tag code to load (0..13 legal) |
| busy_o | output | 32 | Per-entry busy flags (tag nonzero) |
| tl_err_o | output | 1 | One-cycle flag for a rejected tag code |

## Verification
A wrong tag shows up in two places one cycle after the faulty edge: on the tag output of any read port pointed at the entry, and on that entry's bit of `busy_o`. An error in inheritance or clearing can then spread, because a later write copies the bad tag into its destination. The bench therefore reads the sources and the destination back right after every operation. A broken priority among write, tag load and clear only appears when two of them target one entry in the same cycle, so each such collision is driven on purpose.

// File: rtl/tagrf_pkg.sv
package tagrf_pkg;
  localparam int TAG_W       = 4;
  localparam int TAG_DEFINED = 14;   // codes 0..13 are legal

  typedef logic [TAG_W-1:0] tag_t;

  // a code is accepted only below the defined range limit
  function automatic logic tag_is_legal(tag_t t);
    return int'(t) < TAG_DEFINED;
  endfunction

  // an entry is occupied when any tag bit is set
  function automatic logic tag_is_busy(tag_t t);
    return |t;
  endfunction
endpackage

// File: rtl/tagrf_tag_ctrl.sv
module tagrf_tag_ctrl
  import tagrf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               ra_addr,
  input  logic [AW-1:0]               rb_addr,
  input  logic                        clr_a,
  input  logic                        clr_b,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic                        tl_en,
  input  logic [AW-1:0]               tl_addr,
  input  tag_t                        tl_tag,
  output logic [NREG-1:0][TAG_W-1:0]  tags_o,
  output logic                        tl_err_o
);
  logic [NREG-1:0][TAG_W-1:0] tags_q;
  tag_t                       inherit_tag;
  logic                       tl_ok;
  logic                       tl_reject;
  logic                       err_q;
  logic [NREG-1:0]            hit_wr;
  logic [NREG-1:0]            hit_tl;
  logic [NREG-1:0]            hit_clr;

  // tag copied into the destination comes from the first source
  assign inherit_tag = tags_q[ra_addr];
  assign tl_ok       = tl_en &&  tag_is_legal(tl_tag);
  assign tl_reject   = tl_en && !tag_is_legal(tl_tag);

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    assign hit_wr[i]  = wr_en && (wr_addr == AW'(i));
    assign hit_tl[i]  = tl_ok && (tl_addr == AW'(i));
    assign hit_clr[i] = (clr_a && (ra_addr == AW'(i))) ||
                        (clr_b && (rb_addr == AW'(i)));

    // priority: result write, then tag load, then clear
    always_ff @(posedge clk) begin
      if (!rst_n)          tags_q[i] <= '0;
      else if (hit_wr[i])  tags_q[i] <= inherit_tag;
      else if (hit_tl[i])  tags_q[i] <= tl_tag;
      else if (hit_clr[i]) tags_q[i] <= '0;
    end

    AST_TAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_wr[i] || hit_tl[i] || hit_clr[i]) |=> $stable(tags_q[i])); // R5
    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tag_is_legal(tags_q[i])); // R7
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= tl_reject;
  end

  assign tags_o   = tags_q;
  assign tl_err_o = err_q;

  AST_INHERIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tags_q[$past(wr_addr)] == $past(tags_q[ra_addr])); // R3
  AST_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
    clr_a && !(wr_en && wr_addr == ra_addr) && !(tl_ok && tl_addr == ra_addr)
    |=> tags_q[$past(ra_addr)] == '0); // R4
  AST_CLEAR_B: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b && !(wr_en && wr_addr == rb_addr) && !(tl_ok && tl_addr == rb_addr)
    |=> tags_q[$past(rb_addr)] == '0); // R4
  AST_TL_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    tl_ok && !(wr_en && wr_addr == tl_addr)
    |=> tags_q[$past(tl_addr)] == $past(tl_tag)); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tl_reject |=> tl_err_o); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tl_reject |=> !tl_err_o); // R7
endmodule

// File: rtl/tagrf_data_store.sv
module tagrf_data_store #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);
  logic [NREG-1:0][DW-1:0] mem_q;

  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                           mem_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(i))  mem_q[i] <= wr_data;
    end
  end

  assign ra_data = mem_q[ra_addr];
  assign rb_data = mem_q[rb_addr];

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_q)); // R4
endmodule

// File: rtl/tagrf_busy_map.sv
module tagrf_busy_map
  import tagrf_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic [NREG-1:0][TAG_W-1:0] tags_i,
  output logic [NREG-1:0]            busy_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_flag
    assign busy_o[i] = tag_is_busy(tags_i[i]);
  end
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile
  import tagrf_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra_addr,
  output logic [DW-1:0]     ra_data,
  output logic [TAG_W-1:0]  ra_tag,
  input  logic [AW-1:0]     rb_addr,
  output logic [DW-1:0]     rb_data,
  output logic [TAG_W-1:0]  rb_tag,
  input  logic              clr_a,
  input  logic              clr_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              tl_en,
  input  logic [AW-1:0]     tl_addr,
  input  logic [TAG_W-1:0]  tl_tag,
  output logic [NREG-1:0]   busy_o,
  output logic              tl_err_o
);
  logic [NREG-1:0][TAG_W-1:0] tags;

  tagrf_tag_ctrl #(.NREG(NREG), .AW(AW)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_addr  (ra_addr),
    .rb_addr  (rb_addr),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .tl_en    (tl_en),
    .tl_addr  (tl_addr),
    .tl_tag   (tl_tag),
    .tags_o   (tags),
    .tl_err_o (tl_err_o)
  );

  tagrf_data_store #(.NREG(NREG), .DW(DW), .AW(AW)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (ra_addr),
    .rb_addr (rb_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ra_data (ra_data),
    .rb_data (rb_data)
  );

  tagrf_busy_map #(.NREG(NREG)) u_busy (
    .tags_i (tags),
    .busy_o (busy_o)
  );

  assign ra_tag = tags[ra_addr];
  assign rb_tag = tags[rb_addr];

  AST_BUSY_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_tag != '0) == busy_o[ra_addr]); // R9
  AST_BUSY_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_tag != '0) == busy_o[rb_addr]); // R9
endmodule

// File: tb/tagged_regfile_tb_top.sv
`timescale 1ns/1ps
module tagged_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  ra_addr, rb_addr, wr_addr, tl_addr;
  logic [31:0] ra_data, rb_data, wr_data;
  logic [3:0]  ra_tag, rb_tag, tl_tag;
  logic        clr_a, clr_b, wr_en, tl_en, tl_err_o;
  logic [31:0] busy_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tagged_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_data(ra_data), .ra_tag(ra_tag),
    .rb_addr(rb_addr), .rb_data(rb_data), .rb_tag(rb_tag),
    .clr_a(clr_a), .clr_b(clr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tl_en(tl_en), .tl_addr(tl_addr), .tl_tag(tl_tag),
    .busy_o(busy_o), .tl_err_o(tl_err_o)
  );

  typedef struct packed {
    logic [3:0] ta, tb;   // tags preloaded into the sources
    logic [4:0] a, b, d;  // first source, second source, destination
    logic       ca, cb;   // clear bits
    logic [3:0] ed, ea, eb; // expected tags of d, a, b afterwards
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  4'd5,  5'd1,  5'd2,  5'd3,  1'b0, 1'b0, 4'd3,  4'd3,  4'd5},
    '{4'd7,  4'd9,  5'd4,  5'd5,  5'd6,  1'b1, 1'b1, 4'd7,  4'd0,  4'd0},
    '{4'd13, 4'd1,  5'd7,  5'd8,  5'd7,  1'b1, 1'b0, 4'd13, 4'd13, 4'd1},
    '{4'd2,  4'd11, 5'd9,  5'd10, 5'd10, 1'b0, 1'b1, 4'd2,  4'd2,  4'd2},
    '{4'd0,  4'd6,  5'd11, 5'd12, 5'd13, 1'b0, 1'b1, 4'd0,  4'd0,  4'd0},
    '{4'd12, 4'd4,  5'd31, 5'd0,  5'd30, 1'b1, 1'b0, 4'd12, 4'd0,  4'd4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    clr_a = 0; clr_b = 0; wr_en = 0; tl_en = 0;
  endtask

  task automatic tload(logic [4:0] a, logic [3:0] t);
    @(negedge clk);
    tl_en = 1; tl_addr = a; tl_tag = t;
    @(negedge clk);
    idle();
  endtask

  task automatic run_op(logic [4:0] a, logic [4:0] b, logic ca, logic cb,
                        logic we, logic [4:0] d, logic [31:0] dat);
    @(negedge clk);
    ra_addr = a; rb_addr = b; clr_a = ca; clr_b = cb;
    wr_en = we; wr_addr = d; wr_data = dat;
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [4:0] a, logic [4:0] b);
    ra_addr = a; rb_addr = b;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    ra_addr = 0; rb_addr = 0; wr_addr = 0; tl_addr = 0;
    wr_data = 0; tl_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    look(5'd5, 5'd17);
    check("R1 busy", busy_o, 32'h0);
    check("R1 err", 32'(tl_err_o), 32'h0);
    check("R1 tag", 32'(ra_tag), 32'h0);
    check("R1 data", rb_data, 32'h0);

    // table of operations
    for (int k = 0; k < NV; k++) begin
      tload(VECS[k].a, VECS[k].ta);
      tload(VECS[k].b, VECS[k].tb);
      run_op(VECS[k].a, VECS[k].b, VECS[k].ca, VECS[k].cb, 1'b1,
             VECS[k].d, 32'hA000_0000 | 32'(k));
      look(VECS[k].a, VECS[k].b);
      check("R4/R5/R6 src a tag", 32'(ra_tag), 32'(VECS[k].ea));
      check("R4/R5/R6 src b tag", 32'(rb_tag), 32'(VECS[k].eb));
      check("R9 busy a", 32'(busy_o[VECS[k].a]), 32'(VECS[k].ea != 0));
      look(VECS[k].d, VECS[k].b);
      check("R3 dst tag", 32'(ra_tag), 32'(VECS[k].ed));
      check("R3 dst data", ra_data, 32'hA000_0000 | 32'(k));
      check("R9 busy d", 32'(busy_o[VECS[k].d]), 32'(VECS[k].ed != 0));
    end

    // R9: flag moves only after the edge
    @(negedge clk);
    tl_en = 1; tl_addr = 5'd25; tl_tag = 4'd4;
    #1 check("R9 before edge", 32'(busy_o[25]), 32'h0);
    @(negedge clk); idle();
    check("R9 after edge", 32'(busy_o[25]), 32'h1);
    look(5'd25, 5'd0);
    check("R2 comb read tag", 32'(ra_tag), 32'h4);

    // R7: undefined codes rejected, one-cycle error
    @(negedge clk);
    tl_en = 1; tl_addr = 5'd25; tl_tag = 4'd14;
    @(negedge clk); idle();
    check("R7 err raised", 32'(tl_err_o), 32'h1);
    look(5'd25, 5'd26);
    check("R7 tag kept", 32'(ra_tag), 32'h4);
    @(negedge clk);
    check("R7 err one cycle", 32'(tl_err_o), 32'h0);
    tload(5'd26, 4'd15);
    look(5'd26, 5'd0);
    check("R7 code 15 rejected", 32'(ra_tag), 32'h0);
    check("R7 busy after reject", 32'(busy_o[26]), 32'h0);
    tload(5'd25, 4'd0);
    look(5'd25, 5'd0);
    check("R7 code 0 accepted", 32'(ra_tag), 32'h0);

    // R8: write beats tag load on the same entry
    tload(5'd21, 4'd9);
    @(negedge clk);
    ra_addr = 5'd21; wr_en = 1; wr_addr = 5'd20; wr_data = 32'h1234_5678;
    tl_en = 1; tl_addr = 5'd20; tl_tag = 4'd3;
    @(negedge clk); idle();
    look(5'd20, 5'd21);
    check("R8 write over load", 32'(ra_tag), 32'h9);
    check("R8 data", ra_data, 32'h1234_5678);

    // R10: tag load beats clear on the same entry
    tload(5'd22, 4'd6);
    @(negedge clk);
    ra_addr = 5'd22; clr_a = 1; tl_en = 1; tl_addr = 5'd22; tl_tag = 4'd8;
    @(negedge clk); idle();
    look(5'd22, 5'd0);
    check("R10 load over clear", 32'(ra_tag), 32'h8);

    // R4: clearing keeps data
    run_op(5'd21, 5'd0, 1'b0, 1'b0, 1'b1, 5'd27, 32'hCAFE_0027);
    run_op(5'd27, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
    look(5'd27, 5'd21);
    check("R4 cleared tag", 32'(ra_tag), 32'h0);
    check("R4 data kept", ra_data, 32'hCAFE_0027);
    check("R5 untouched keeps", 32'(rb_tag), 32'h9);

    // R1: reset after activity
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look(5'd20, 5'd27);
    check("R1 busy after reset", busy_o, 32'h0);
    check("R1 data after reset", ra_data, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule